// File: doc/BRIEF.md
# Glitch-Free Output Enable Gating

This block gates a bank of differential clock outputs under a small set of asynchronous group-enable pins. Each output is a true/complement pair of digital signals derived from its own source clock. A per-output "stoppable" bit selects which outputs obey the enables, and a per-output group field selects which enable pin an output follows. Outputs whose bit is clear keep running whatever the pins do.

When the pin of its group goes low, a stoppable output completes the high phase it is in and then parks with both legs low. When the pin returns high, every parked output in the released groups restarts on the same reference-clock cycle, a few cycles later, with no shortened pulse. The source clocks are assumed to be produced inside the reference clock domain: they change only between reference-clock edges. Each output's pair is registered, so a running pair is its source delayed by one reference cycle.

Top module: `oe_clock_gate`

## Requirements
- R1: While reset is held, both legs of every pair are 0 and every status bit reads 1 (stopped).
- R2: A running output drives its true leg equal to its source clock one reference cycle earlier and its complement leg to the inverse of that value.
- R3: When the pin of its group goes low, a stoppable output reaches both legs low with its status bit set within 6 reference cycles, for sources with a high phase of one cycle.
- R4: An output whose stoppable bit is 0 keeps following its source and shows status 0 whatever its group pin does.
- R5: Output i follows the enable pin whose index is the 2-bit field at bit positions 2*i+1 down to 2*i of the group select bus.
- R6: The true leg never shows a high phase shorter than the high phase of its source, across stop and restart.
- R7: After a group pin returns high, its stopped outputs become active (either leg high) between 2 and 6 reference cycles later, for sources that toggle every reference cycle.
- R8: Stopped outputs released together whose sources are in phase all become active on the same reference cycle.
- R9: An output's gate (its status bit) changes only after a reference edge at which its source was low.
- R10: The two legs of a pair are never high at the same time.
- R11: The status bit of an output is 1 exactly when it is gated off, and a gated-off output has both legs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Internal reference clock |
| rst_ref_n | input | 1 | Synchronous active-low reset |
| src_clk | input | N_OUT | Per-output source clocks, changing only between reference edges |
| oe_pin | input | N_GRP | Asynchronous group enable pins, high means enabled |
| stop_mask | input | N_OUT | Per-output stoppable bit |
| grp_sel | input | N_OUT*GW | Per-output group index, GW bits each |
| out_p | output | N_OUT | True legs of the output pairs |
| out_n | output | N_OUT | Complement legs of the output pairs |
| stopped | output | N_OUT | Per-output status, 1 when gated off |

## Verification
The properties assume the source clocks are synchronous to the reference clock and stable at each reference edge, so that the level sampled at an edge is the level the gate decision used; the bench drives every source and every control input only on the falling reference edge. The stop-mask property also assumes the mask seen at an edge is the one used there, which holds because the mask changes only between edges. Latency and lockstep checks rely on sources that start together and toggle every cycle, so the only slow source is kept non-stoppable during those tests and is exercised on its own for pulse width.

// File: rtl/oegate_pkg.sv
// Package: shared types and helpers for the output-enable gating block.
// Assumes nothing beyond a single reference clock domain.
package oegate_pkg;

    // Per-group release state: off, waiting out the extra delay, on.
    typedef enum logic [1:0] {
        REL_OFF  = 2'd0,
        REL_WAIT = 2'd1,
        REL_ON   = 2'd2
    } rel_state_e;

    // Width of a counter that must hold values 0..max_val (at least 1 bit).
    function automatic int cnt_width(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

    // Width of an index selecting one of n items (at least 1 bit).
    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/oegate_sync.sv
// Module: oegate_sync
// Brings each asynchronous enable pin into the reference domain through
// a two-flop synchronizer. Assumes the pins are level signals held for
// several reference cycles; a pulse shorter than one cycle may be lost.
module oegate_sync #(
    parameter int N_GRP = 4
) (
    input  logic             clk_ref,
    input  logic             rst_ref_n,
    input  logic [N_GRP-1:0] pin_async,
    output logic [N_GRP-1:0] pin_sync
);

    logic [N_GRP-1:0] meta_q;
    logic [N_GRP-1:0] sync_q;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_sync
            // Two-stage capture of one enable pin; resets to disabled.
            always_ff @(posedge clk_ref) begin
                if (!rst_ref_n) begin
                    meta_q[g] <= 1'b0;
                    sync_q[g] <= 1'b0;
                end else begin
                    meta_q[g] <= pin_async[g];
                    sync_q[g] <= meta_q[g];
                end
            end
        end
    endgenerate

    assign pin_sync = sync_q;

endmodule

// File: rtl/oegate_release.sv
// Module: oegate_release
// Turns each synchronized enable into a group-on flag. A falling enable
// turns the group off on the next edge; a rising enable turns it on after
// RESUME_EXTRA further cycles, so every output of the group sees the
// release on one and the same cycle. Assumes synchronized inputs.
module oegate_release
    import oegate_pkg::*;
#(
    parameter int N_GRP        = 4,
    parameter int RESUME_EXTRA = 0
) (
    input  logic             clk_ref,
    input  logic             rst_ref_n,
    input  logic [N_GRP-1:0] en_sync,
    output logic [N_GRP-1:0] grp_on
);

    localparam int CW = cnt_width(RESUME_EXTRA);
    localparam logic [CW-1:0] CNT_LAST = CW'(RESUME_EXTRA);

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_rel
            rel_state_e    state_q;
            logic [CW-1:0] cnt_q;

            // Release state machine and delay counter for one group.
            always_ff @(posedge clk_ref) begin
                if (!rst_ref_n) begin
                    state_q <= REL_OFF;
                    cnt_q   <= '0;
                end else begin
                    case (state_q)
                        REL_OFF: begin
                            cnt_q <= '0;
                            if (en_sync[g]) state_q <= REL_WAIT;
                        end
                        REL_WAIT: begin
                            if (!en_sync[g]) begin
                                state_q <= REL_OFF;
                                cnt_q   <= '0;
                            end else if (cnt_q == CNT_LAST) begin
                                state_q <= REL_ON;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                        REL_ON: begin
                            if (!en_sync[g]) state_q <= REL_OFF;
                        end
                        default: state_q <= REL_OFF;
                    endcase
                end
            end

            assign grp_on[g] = (state_q == REL_ON);
        end
    endgenerate

endmodule

// File: rtl/oegate_map.sv
// Module: oegate_map
// Decides, per output, whether its gate should be open: outputs that are
// not stoppable always request open; stoppable ones follow their group.
// A group index beyond N_GRP reads as "group off". Purely combinational.
module oegate_map
    import oegate_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int N_GRP = 4,
    localparam int GW   = idx_width(N_GRP)
) (
    input  logic [N_OUT-1:0]    stop_mask,
    input  logic [N_OUT*GW-1:0] grp_sel,
    input  logic [N_GRP-1:0]    grp_on,
    output logic [N_OUT-1:0]    gate_req
);

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_map
            logic [GW-1:0] idx;
            logic          grp_level;

            assign idx = grp_sel[i*GW +: GW];

            // Look up the group-on flag selected for this output.
            always_comb begin
                grp_level = 1'b0;
                for (int g = 0; g < N_GRP; g++) begin
                    if (idx == GW'(g)) grp_level = grp_on[g];
                end
            end

            assign gate_req[i] = ~stop_mask[i] | grp_level;
        end
    endgenerate

endmodule

// File: rtl/oegate_lane.sv
// Module: oegate_lane
// One output pair. The gate may change only on an edge where the source
// is low, so a high phase is never cut short and a restart always begins
// at a low phase. The pair is registered one cycle behind the source.
// Assumes the source changes only between reference edges.
module oegate_lane (
    input  logic clk_ref,
    input  logic rst_ref_n,
    input  logic src,
    input  logic gate_req,
    output logic leg_p,
    output logic leg_n,
    output logic is_stopped
);

    logic run_q;
    logic run_nxt;
    logic p_q;
    logic n_q;

    // Next gate state: hold while the source is high, else take the request.
    always_comb begin
        run_nxt = src ? run_q : gate_req;
    end

    // Gate flop and registered pair.
    always_ff @(posedge clk_ref) begin
        if (!rst_ref_n) begin
            run_q <= 1'b0;
            p_q   <= 1'b0;
            n_q   <= 1'b0;
        end else begin
            run_q <= run_nxt;
            p_q   <= src & run_nxt;
            n_q   <= ~src & run_nxt;
        end
    end

    assign leg_p      = p_q;
    assign leg_n      = n_q;
    assign is_stopped = ~run_q;

endmodule

// File: rtl/oe_clock_gate.sv
// Module: oe_clock_gate (top)
// Gates N_OUT differential clock pairs under N_GRP asynchronous group
// enables. Pins are synchronized, turned into per-group release flags,
// mapped to outputs through the stoppable mask and group select, and
// applied by one lane per output. Assumes sources are synchronous to clk_ref.
module oe_clock_gate
    import oegate_pkg::*;
#(
    parameter int N_OUT        = 8,
    parameter int N_GRP        = 4,
    parameter int RESUME_EXTRA = 0,
    localparam int GW          = idx_width(N_GRP)
) (
    input  logic                clk_ref,
    input  logic                rst_ref_n,
    input  logic [N_OUT-1:0]    src_clk,
    input  logic [N_GRP-1:0]    oe_pin,
    input  logic [N_OUT-1:0]    stop_mask,
    input  logic [N_OUT*GW-1:0] grp_sel,
    output logic [N_OUT-1:0]    out_p,
    output logic [N_OUT-1:0]    out_n,
    output logic [N_OUT-1:0]    stopped
);

    logic [N_GRP-1:0] en_sync;
    logic [N_GRP-1:0] grp_on;
    logic [N_OUT-1:0] gate_req;

    oegate_sync #(.N_GRP(N_GRP)) sync_i (
        .clk_ref   (clk_ref),
        .rst_ref_n (rst_ref_n),
        .pin_async (oe_pin),
        .pin_sync  (en_sync)
    );

    oegate_release #(.N_GRP(N_GRP), .RESUME_EXTRA(RESUME_EXTRA)) rel_i (
        .clk_ref   (clk_ref),
        .rst_ref_n (rst_ref_n),
        .en_sync   (en_sync),
        .grp_on    (grp_on)
    );

    oegate_map #(.N_OUT(N_OUT), .N_GRP(N_GRP)) map_i (
        .stop_mask (stop_mask),
        .grp_sel   (grp_sel),
        .grp_on    (grp_on),
        .gate_req  (gate_req)
    );

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_lane
            oegate_lane lane_i (
                .clk_ref    (clk_ref),
                .rst_ref_n  (rst_ref_n),
                .src        (src_clk[i]),
                .gate_req   (gate_req[i]),
                .leg_p      (out_p[i]),
                .leg_n      (out_n[i]),
                .is_stopped (stopped[i])
            );
        end
    endgenerate

endmodule

// File: rtl/oegate_chk.sv
// Module: oegate_chk
// Property checker bound to oe_clock_gate. Assumes sources and the mask
// change only between reference edges.
module oegate_chk #(
    parameter int N_OUT = 8
) (
    input logic             clk_ref,
    input logic             rst_ref_n,
    input logic [N_OUT-1:0] src_clk,
    input logic [N_OUT-1:0] stop_mask,
    input logic [N_OUT-1:0] out_p,
    input logic [N_OUT-1:0] out_n,
    input logic [N_OUT-1:0] stopped
);

    AST_LEGS_EXCLUSIVE: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
        (out_p & out_n) == '0); // R10

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_prop
            AST_STOPPED_LOW: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
                stopped[i] |-> (!out_p[i] && !out_n[i])); // R11

            AST_GATE_MOVES_LOW: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
                !$stable(stopped[i]) |-> !$past(src_clk[i])); // R9

            AST_FIXED_KEEPS_RUN: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
                (!stopped[i] && !stop_mask[i]) |=> !stopped[i]); // R4

            AST_RUN_FOLLOWS_SRC: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
                (!stopped[i] && $past(!stopped[i])) |-> (out_p[i] == $past(src_clk[i]))); // R2
        end
    endgenerate

endmodule

bind oe_clock_gate oegate_chk #(.N_OUT(N_OUT)) chk_i (
    .clk_ref   (clk_ref),
    .rst_ref_n (rst_ref_n),
    .src_clk   (src_clk),
    .stop_mask (stop_mask),
    .out_p     (out_p),
    .out_n     (out_n),
    .stopped   (stopped)
);

// File: tb/oe_clock_gate_tb_top.sv
// Directed bench for oe_clock_gate: one task per scenario.
module oe_clock_gate_tb_top;

    localparam int N_OUT = 8;
    localparam int N_GRP = 4;
    localparam int GW    = 2;
    localparam int HP [N_OUT] = '{1, 1, 1, 1, 1, 3, 1, 1};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N_OUT-1:0]    src = '0;
    logic [N_GRP-1:0]    oe = '1;
    logic [N_OUT-1:0]    mask = 8'b1100_1111;
    logic [N_OUT*GW-1:0] gsel;
    logic [N_OUT-1:0]    out_p, out_n, stopped;

    int checks = 0;
    int fails = 0;
    int mon_err = 0;
    int runt_err = 0;
    int both_err = 0;
    int ph [N_OUT];
    int hi_len [N_OUT];
    bit done = 0;

    always #2 clk = ~clk;

    oe_clock_gate #(.N_OUT(N_OUT), .N_GRP(N_GRP)) dut_i (
        .clk_ref   (clk),
        .rst_ref_n (rst_n),
        .src_clk   (src),
        .oe_pin    (oe),
        .stop_mask (mask),
        .grp_sel   (gsel),
        .out_p     (out_p),
        .out_n     (out_n),
        .stopped   (stopped)
    );

    // Source generator: output i toggles every HP[i] falling edges.
    always @(negedge clk) begin
        for (int i = 0; i < N_OUT; i++) begin
            if (ph[i] >= HP[i] - 1) begin
                src[i] <= ~src[i];
                ph[i] = 0;
            end else begin
                ph[i] = ph[i] + 1;
            end
        end
    end

    // Cycle monitor: pair follows source (R2, R11), legs exclusive (R10), full high phases (R6).
    always @(posedge clk) begin
        #1;
        for (int i = 0; i < N_OUT; i++) begin
            if (!rst_n) begin
                hi_len[i] = 0;
            end else begin
                if (out_p[i] !== (src[i] & ~stopped[i]) || out_n[i] !== (~src[i] & ~stopped[i]))
                    mon_err++;
                if (out_p[i] && out_n[i]) both_err++;
                if (out_p[i]) begin
                    hi_len[i]++;
                end else begin
                    if (hi_len[i] != 0 && hi_len[i] != HP[i]) runt_err++;
                    hi_len[i] = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N_OUT-1:0] exp_stopped();
        logic [N_OUT-1:0] r;
        for (int i = 0; i < N_OUT; i++)
            r[i] = mask[i] & ~oe[gsel[i*GW +: GW]];
        return r;
    endfunction

    task automatic wait_samples(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        wait_samples(4);
        chk(out_p == '0 && out_n == '0, "R1 legs low in reset", {out_p, out_n}, 0);
        chk(stopped == '1, "R1 status in reset", stopped, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;
        wait_samples(12);
        chk(stopped == '0, "R2 all running after reset", stopped, 0);
    endtask

    // R3, R4: stop group 0 holding one stoppable and one fixed output.
    task automatic t_stop();
        int e0;
        e0 = mon_err;
        @(negedge clk);
        oe[0] = 1'b0;
        wait_samples(6);
        chk(stopped == 8'b0000_0001, "R3 stoppable output stopped", stopped, 1);
        chk(!out_p[0] && !out_n[0], "R3 stopped pair both low", {out_p[0], out_n[0]}, 0);
        chk(!stopped[4], "R4 fixed output keeps running", stopped[4], 0);
        wait_samples(6);
        chk(mon_err == e0, "R4 fixed output follows source", mon_err - e0, 0);
        @(negedge clk);
        oe[0] = 1'b1;
        wait_samples(10);
        chk(stopped == '0, "R3 group 0 restarted", stopped, 0);
    endtask

    // R5: remap output 2 to group 3 and drop pin 3.
    task automatic t_map();
        @(negedge clk);
        gsel[2*GW +: GW] = 2'd3;
        oe[3] = 1'b0;
        wait_samples(8);
        chk(stopped == 8'b1000_1100, "R5 remapped group stops", stopped, 8'h8C);
        chk(stopped == exp_stopped(), "R5 stop set matches map", stopped, exp_stopped());
        @(negedge clk);
        oe[3] = 1'b1;
        gsel[2*GW +: GW] = 2'd2;
        wait_samples(10);
        chk(stopped == '0, "R5 restored", stopped, 0);
    endtask

    // R7, R8: release all groups together, measure latency and lockstep.
    task automatic t_resume();
        int first_k;
        logic [N_OUT-1:0] stp;
        first_k = 0;
        @(negedge clk);
        mask = 8'b1101_1111;
        oe = '0;
        wait_samples(8);
        chk(stopped == 8'b1101_1111, "R11 all stoppable parked", stopped, 8'hDF);
        stp = mask;
        @(negedge clk);
        oe = '1;
        for (int k = 1; k <= 9; k++) begin
            @(posedge clk);
            #1;
            if (first_k == 0 && ((out_p | out_n) & stp) != '0) begin
                first_k = k;
                chk(((out_p | out_n) & stp) == stp, "R8 all restart same cycle",
                    (out_p | out_n) & stp, stp);
            end
        end
        chk(first_k >= 2 && first_k <= 6, "R7 restart latency", first_k, 6);
        wait_samples(4);
        chk(stopped == '0, "R7 all running", stopped, 0);
    endtask

    // R6: stop and restart the slow output at several phases.
    task automatic t_slow();
        int r0;
        r0 = runt_err;
        @(negedge clk);
        mask = 8'b1110_1111;
        for (int off = 0; off < 3; off++) begin
            repeat (off + 1) @(negedge clk);
            oe[1] = 1'b0;
            wait_samples(12);
            chk(stopped[5] && stopped[1], "R3 slow group stopped", {stopped[5], stopped[1]}, 3);
            @(negedge clk);
            oe[1] = 1'b1;
            wait_samples(14);
        end
        chk(runt_err == r0, "R6 no shortened high phase", runt_err - r0, 0);
        chk(stopped == '0, "R6 slow group restarted", stopped, 0);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        for (int i = 0; i < N_OUT; i++) begin
            ph[i] = 0;
            hi_len[i] = 0;
            gsel[i*GW +: GW] = GW'(i % N_GRP);
        end
        t_reset();
        t_stop();
        t_map();
        t_resume();
        t_slow();
        chk(mon_err == 0, "R2 pair tracks source", mon_err, 0);
        chk(both_err == 0, "R10 legs never both high", both_err, 0);
        chk(runt_err == 0, "R6 runt count", runt_err, 0);
        finish_up();
    end

endmodule